// File: doc/BRIEF.md
# Programmable 16-bit Down-Counter Timer

This block is a byte-programmed 16-bit down-counter. Software loads a start value as two bytes, chooses an output shape and a set of options in a mode byte, and controls the counter through a command byte that carries a gate, a trigger, a count-capture request and an interrupt acknowledge. When the count runs out the block raises an interrupt-pending flag and shapes its output pin as a one-shot window, a single-clock pulse or a square wave. With automatic reload and retrigger options, the six usual interval-timer behaviours can be built from these pieces.

Control is a three-state machine. ST_OFF is held while the master enable is clear. The *enable* transition moves ST_OFF to ST_IDLE. The *start* transition moves ST_IDLE to ST_RUN on an accepted trigger. The *expire* transition returns ST_RUN to ST_IDLE at terminal count when automatic reload is off. The *disable* transition moves any state to ST_OFF when the master enable drops. Two events keep ST_RUN: *rearm*, a trigger during counting with retrigger on, and *cycle*, a terminal count with automatic reload on.

Register map (3-bit address, byte data): 0 reload low byte, 1 reload high byte, 2 mode, 3 command/status, 4 count view high byte, 5 count view low byte, 6 master enable (bit 0).

Top module: `cnt_timer16`

## Requirements
- R1: After an accepted trigger loads a reload value N (address 0 low byte, address 1 high byte), the count drops by one per tick, and terminal count is reached on the Nth tick. Status bit 5 (counting) is 1 from the trigger until terminal count.
- R2: Terminal count sets status bit 6 and `irq`. Both stay set until a command write with bit 3 (acknowledge). If a terminal count and an acknowledge fall in the same cycle, the flag stays set.
- R3: With mode bits [1:0]=00 (one-shot), the output is high exactly while the counter is counting.
- R4: With mode bits [1:0]=01 (pulse), the output is high for the one clock after each terminal count.
- R5: With mode bits [1:0]=10 (square) and automatic reload, the output goes high at the trigger and toggles at every terminal count. Reload N gives N clocks high and N clocks low.
- R6: Mode bit 2 (automatic reload) reloads the count at terminal count and keeps counting. Without it, the count stops at 0 and the block returns to idle.
- R7: Mode bit 7 (retrigger) makes a trigger during counting reload the count, and this reload wins over a terminal count in the same cycle. Without it, a trigger during counting has no effect.
- R8: Command bit 0 is the gate, and every command write sets it to the written value. With the gate clear the count holds and a trigger is ignored. A write that sets gate and trigger (bit 1) together starts the counter.
- R9: Command bit 2 copies the count into the view registers (address 4 high, address 5 low) and freezes them, with status bit 2 set. A read of address 5 releases the freeze. Unfrozen view registers show the live count.
- R10: Address 6 bit 0 is the master enable, and it is 0 after reset. While it is clear, counting stops (status bit 5 is 0), the count holds and triggers are ignored.
- R11: Mode bit 3 makes the counter count rising edges of `ext_clk_in` instead of clocks.
- R12: Mode bit 4 makes a rising edge of `ext_trig_in` act as a trigger.
- R13: Mode bit 5 makes the counter count only while `ext_gate_in` is high.
- R14: Mode bit 6 enables the output. While it is clear, `tmr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; needed only to release the frozen view |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_clk_in | input | 1 | External count source, rising edges |
| ext_trig_in | input | 1 | External trigger, rising edges |
| ext_gate_in | input | 1 | External count gate, active high |
| tmr_out | output | 1 | Shaped timer output |
| irq | output | 1 | Interrupt pending |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a retrigger and a terminal count. The bench writes a trigger on the exact clock in which a count of 1 would expire. It then expects the counting bit set, the pending bit clear, and a count one below the reload value on the following clock. The second pair is an acknowledge and a new terminal count. The bench writes the acknowledge on the expiring clock and expects the pending flag to remain set.

// File: rtl/cnt_timer16_pkg.sv
package cnt_timer16_pkg;

    // Control states of the counter
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    // Output shape selection, mode bits [1:0]
    typedef enum logic [1:0] {
        SHP_ONESHOT = 2'd0,
        SHP_PULSE   = 2'd1,
        SHP_SQUARE  = 2'd2,
        SHP_SPARE   = 2'd3
    } shape_e;

    // Mode byte, msb first
    typedef struct packed {
        logic   retrig;   // bit 7
        logic   out_en;   // bit 6
        logic   x_gate;   // bit 5
        logic   x_trig;   // bit 4
        logic   x_count;  // bit 3
        logic   cont;     // bit 2
        shape_e shape;    // bits 1:0
    } mode_t;

    // Register addresses
    localparam int unsigned ADR_RLD_LO = 0;
    localparam int unsigned ADR_MODE   = 2;
    localparam int unsigned ADR_CMD    = 3;
    localparam int unsigned ADR_VIEW_H = 4;
    localparam int unsigned ADR_VIEW_L = 5;
    localparam int unsigned ADR_MASTER = 6;

    // Command bits (write)
    localparam int unsigned CB_GATE = 0;
    localparam int unsigned CB_TRIG = 1;
    localparam int unsigned CB_CAPT = 2;
    localparam int unsigned CB_ACK  = 3;

    // Status bits (read)
    localparam int unsigned SB_GATE = 0;
    localparam int unsigned SB_FROZ = 2;
    localparam int unsigned SB_CIP  = 5;
    localparam int unsigned SB_PEND = 6;

endpackage

// File: rtl/cnt_timer16_edge.sv
module cnt_timer16_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/cnt_timer16_regs.sv
module cnt_timer16_regs
    import cnt_timer16_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              cip,
    input  logic              pend,
    output logic [CNT_W-1:0]  reload,
    output mode_t             mode,
    output logic              master_en,
    output logic              gate_eff,
    output logic              trig_sw,
    output logic              ack_cmd
);

    localparam int unsigned NBYTES = CNT_W / DATA_W;

    logic [DATA_W-1:0] rld_byte [NBYTES];
    mode_t             mode_q;
    logic              master_q;
    logic              gate_q;
    logic              frozen_q;
    logic [CNT_W-1:0]  cap_q;
    logic [CNT_W-1:0]  view;
    logic              cmd_wr;
    logic              cap_cmd;
    logic              view_lo_rd;
    logic [DATA_W-1:0] status;

    assign cmd_wr     = wr_en && (addr == ADDR_W'(ADR_CMD));
    assign gate_eff   = cmd_wr ? wdata[CB_GATE] : gate_q;
    assign trig_sw    = cmd_wr && wdata[CB_TRIG];
    assign cap_cmd    = cmd_wr && wdata[CB_CAPT];
    assign ack_cmd    = cmd_wr && wdata[CB_ACK];
    assign view_lo_rd = rd_en && (addr == ADDR_W'(ADR_VIEW_L));

    // Reload bytes, one register per byte lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_rld
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rld_byte[b] <= '0;
            else if (wr_en && (addr == ADDR_W'(ADR_RLD_LO + b)))
                rld_byte[b] <= wdata;
        end
        assign reload[b*DATA_W +: DATA_W] = rld_byte[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            master_q <= 1'b0;
            gate_q   <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(ADR_MODE))   mode_q   <= mode_t'(wdata[7:0]);
            if (addr == ADDR_W'(ADR_MASTER)) master_q <= wdata[0];
            if (cmd_wr)                      gate_q   <= wdata[CB_GATE];
        end
    end

    // Count view: capture wins over a release in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q    <= '0;
            frozen_q <= 1'b0;
        end else if (cap_cmd) begin
            cap_q    <= count;
            frozen_q <= 1'b1;
        end else if (view_lo_rd) begin
            frozen_q <= 1'b0;
        end
    end

    assign view      = frozen_q ? cap_q : count;
    assign mode      = mode_q;
    assign master_en = master_q;

    always_comb begin
        status          = '0;
        status[SB_GATE] = gate_q;
        status[SB_FROZ] = frozen_q;
        status[SB_CIP]  = cip;
        status[SB_PEND] = pend;
    end

    always_comb begin
        unique case (addr)
            ADDR_W'(ADR_RLD_LO):     rdata = rld_byte[0];
            ADDR_W'(ADR_RLD_LO + 1): rdata = rld_byte[NBYTES-1];
            ADDR_W'(ADR_MODE):       rdata = DATA_W'(mode_q);
            ADDR_W'(ADR_CMD):        rdata = status;
            ADDR_W'(ADR_VIEW_H):     rdata = view[CNT_W-1 -: DATA_W];
            ADDR_W'(ADR_VIEW_L):     rdata = view[DATA_W-1:0];
            ADDR_W'(ADR_MASTER):     rdata = DATA_W'(master_q);
            default:                 rdata = '0;
        endcase
    end

    // R9: reading the low view byte releases a freeze unless a capture coincides
    assert_view_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (view_lo_rd && frozen_q && !cap_cmd) |=> !frozen_q);

    // R8: every command write leaves the gate at the written value
    assert_gate_follows_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (gate_q == $past(wdata[CB_GATE])));

endmodule

// File: rtl/cnt_timer16_core.sv
module cnt_timer16_core
    import cnt_timer16_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             gate_eff,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] reload,
    input  logic             trig_req,
    input  logic             ack_cmd,
    input  logic             x_count_rise,
    input  logic             ext_gate_in,
    output logic [CNT_W-1:0] count,
    output logic             cip,
    output logic             pend,
    output logic             shape_out
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             pend_q;
    logic             pulse_q;
    logic             sq_q;

    logic ext_gate_ok, tick, trig_hit, start, rearm, tick_en, at_end, tc_hit;

    assign ext_gate_ok = !mode.x_gate || ext_gate_in;
    assign tick        = mode.x_count ? x_count_rise : 1'b1;
    assign trig_hit    = master_en && gate_eff && trig_req;
    assign start       = (state_q == ST_IDLE) && trig_hit;
    assign rearm       = (state_q == ST_RUN) && trig_hit && mode.retrig;
    assign tick_en     = (state_q == ST_RUN) && master_en && gate_eff && ext_gate_ok && tick;
    assign at_end      = tick_en && (count_q <= ONE);
    assign tc_hit      = at_end && !rearm;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (master_en) state_d = ST_IDLE;                    // enable
            ST_IDLE: if (!master_en) state_d = ST_OFF;                    // disable
                     else if (start) state_d = ST_RUN;                    // start
            ST_RUN:  if (!master_en) state_d = ST_OFF;                    // disable
                     else if (tc_hit && !mode.cont) state_d = ST_IDLE;    // expire
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Count datapath: load on start/rearm, reload or empty at terminal count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count_q <= '0;
        else if (start || rearm) count_q <= reload;
        else if (tc_hit)         count_q <= mode.cont ? reload : '0;
        else if (tick_en)        count_q <= count_q - ONE;
    end

    // Output process: pending flag, pulse and square-wave registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
            sq_q    <= 1'b0;
        end else begin
            if (tc_hit)       pend_q <= 1'b1;
            else if (ack_cmd) pend_q <= 1'b0;
            pulse_q <= tc_hit;
            if (start)        sq_q <= 1'b1;
            else if (tc_hit)  sq_q <= ~sq_q;
        end
    end

    always_comb begin
        unique case (mode.shape)
            SHP_ONESHOT: shape_out = (state_q == ST_RUN);
            SHP_PULSE:   shape_out = pulse_q;
            SHP_SQUARE:  shape_out = sq_q;
            SHP_SPARE:   shape_out = (state_q == ST_RUN);
            default:     shape_out = 1'b0;
        endcase
    end

    assign count = count_q;
    assign cip   = (state_q == ST_RUN);
    assign pend  = pend_q;

    // R10: a cleared master enable forces the off state next cycle
    assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (state_q == ST_OFF));

    // R2: the pending flag only rises after a counting tick
    assert_pend_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(tick_en));

    // R1: an ordinary tick lowers the count by exactly one
    assert_decrement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (count_q > ONE) && !rearm) |=> (count_q == $past(count_q) - ONE));

    // R7: without retrigger, a trigger while counting leaves the count alone
    assert_no_retrig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && trig_hit && !mode.retrig && !tick_en) |=> $stable(count_q));

    // R8: with the gate closed the count holds
    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_eff |=> $stable(count_q));

endmodule

// File: rtl/cnt_timer16.sv
module cnt_timer16
    import cnt_timer16_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              ext_trig_in,
    input  logic              ext_gate_in,
    output logic              tmr_out,
    output logic              irq
);

    localparam int unsigned N_EDGE = 2;

    logic [CNT_W-1:0]  count, reload;
    logic              cip, pend, master_en, gate_eff, trig_sw, ack_cmd, shape_out;
    mode_t             mode;
    logic [N_EDGE-1:0] rise;
    logic              trig_req;

    cnt_timer16_edge #(.N(N_EDGE)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({ext_trig_in, ext_clk_in}),
        .rise  (rise)
    );

    cnt_timer16_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .count     (count),
        .cip       (cip),
        .pend      (pend),
        .reload    (reload),
        .mode      (mode),
        .master_en (master_en),
        .gate_eff  (gate_eff),
        .trig_sw   (trig_sw),
        .ack_cmd   (ack_cmd)
    );

    assign trig_req = trig_sw || (mode.x_trig && rise[1]);

    cnt_timer16_core #(.CNT_W(CNT_W)) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .gate_eff     (gate_eff),
        .mode         (mode),
        .reload       (reload),
        .trig_req     (trig_req),
        .ack_cmd      (ack_cmd),
        .x_count_rise (rise[0]),
        .ext_gate_in  (ext_gate_in),
        .count        (count),
        .cip          (cip),
        .pend         (pend),
        .shape_out    (shape_out)
    );

    assign tmr_out = mode.out_en & shape_out;
    assign irq     = pend;

    // R14: output stays low while the output enable is clear
    assert_out_gated_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.out_en |-> !tmr_out);

endmodule

// File: tb/test_cnt_timer16.sv
module test_cnt_timer16;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PIN = 3'd2, OP_IDLE = 3'd3, OP_EXT = 3'd4;
    localparam int NV = 52;
    // {op, addr, data, expected, requirement}
    localparam logic [25:0] VEC [NV] = '{
        {OP_WR,  3'd6, 8'h01, 8'h00, 4'd10},  // R10 master on
        {OP_WR,  3'd2, 8'h40, 8'h00, 4'd3},   // R3 one-shot, output on
        {OP_WR,  3'd0, 8'h05, 8'h00, 4'd1},   // R1 reload low
        {OP_WR,  3'd1, 8'h00, 8'h00, 4'd1},   // R1 reload high
        {OP_WR,  3'd3, 8'h03, 8'h00, 4'd1},   // R1 gate+trigger
        {OP_PIN, 3'd0, 8'h00, 8'h01, 4'd3},   // R3 output high while counting
        {OP_RD,  3'd3, 8'h00, 8'h21, 4'd1},   // R1 counting
        {OP_IDLE,3'd0, 8'd2,  8'h00, 4'd1},
        {OP_RD,  3'd3, 8'h00, 8'h21, 4'd1},   // R1 still counting at count 1
        {OP_PIN, 3'd0, 8'h00, 8'h02, 4'd2},   // R2 irq, R3 output low
        {OP_RD,  3'd3, 8'h00, 8'h41, 4'd2},   // R2 pending
        {OP_RD,  3'd5, 8'h00, 8'h00, 4'd6},   // R6 stopped at 0
        {OP_WR,  3'd3, 8'h09, 8'h00, 4'd2},   // R2 acknowledge
        {OP_PIN, 3'd0, 8'h00, 8'h00, 4'd2},   // R2 irq cleared
        {OP_WR,  3'd2, 8'h45, 8'h00, 4'd4},   // R4 pulse + reload
        {OP_WR,  3'd0, 8'h03, 8'h00, 4'd6},
        {OP_WR,  3'd3, 8'h03, 8'h00, 4'd6},
        {OP_IDLE,3'd0, 8'd2,  8'h00, 4'd4},
        {OP_PIN, 3'd0, 8'h00, 8'h00, 4'd4},   // R4 no pulse before end
        {OP_PIN, 3'd0, 8'h00, 8'h03, 4'd4},   // R4 pulse after terminal count
        {OP_PIN, 3'd0, 8'h00, 8'h02, 4'd4},   // R4 one clock only
        {OP_RD,  3'd3, 8'h00, 8'h61, 4'd6},   // R6 still counting
        {OP_RD,  3'd5, 8'h00, 8'h03, 4'd6},   // R6 reloaded
        {OP_WR,  3'd6, 8'h00, 8'h00, 4'd10},  // R10 master off
        {OP_IDLE,3'd0, 8'd1,  8'h00, 4'd10},
        {OP_RD,  3'd3, 8'h00, 8'h41, 4'd10},  // R10 not counting
        {OP_WR,  3'd3, 8'h03, 8'h00, 4'd10},  // R10 trigger while off
        {OP_RD,  3'd3, 8'h00, 8'h41, 4'd10},  // R10 ignored
        {OP_RD,  3'd5, 8'h00, 8'h01, 4'd10},  // R10 count held
        {OP_WR,  3'd3, 8'h09, 8'h00, 4'd2},
        {OP_WR,  3'd6, 8'h01, 8'h00, 4'd10},
        {OP_WR,  3'd2, 8'h46, 8'h00, 4'd5},   // R5 square + reload
        {OP_WR,  3'd0, 8'h02, 8'h00, 4'd5},
        {OP_WR,  3'd3, 8'h03, 8'h00, 4'd5},
        {OP_PIN, 3'd0, 8'h00, 8'h01, 4'd5},   // R5 high half
        {OP_PIN, 3'd0, 8'h00, 8'h01, 4'd5},
        {OP_PIN, 3'd0, 8'h00, 8'h02, 4'd5},   // R5 low half
        {OP_PIN, 3'd0, 8'h00, 8'h02, 4'd5},
        {OP_PIN, 3'd0, 8'h00, 8'h03, 4'd5},   // R5 high again
        {OP_WR,  3'd3, 8'h08, 8'h00, 4'd8},   // R8 gate off + ack
        {OP_IDLE,3'd0, 8'd2,  8'h00, 4'd8},
        {OP_RD,  3'd5, 8'h00, 8'h01, 4'd8},   // R8 count held
        {OP_RD,  3'd3, 8'h00, 8'h20, 4'd8},   // R8 gate clear, counting
        {OP_WR,  3'd3, 8'h01, 8'h00, 4'd8},   // R8 gate on resumes
        {OP_RD,  3'd5, 8'h00, 8'h02, 4'd8},   // R8 resumed and reloaded
        {OP_WR,  3'd6, 8'h00, 8'h00, 4'd10},
        {OP_IDLE,3'd0, 8'd1,  8'h00, 4'd10},
        {OP_WR,  3'd3, 8'h08, 8'h00, 4'd2},
        {OP_WR,  3'd6, 8'h01, 8'h00, 4'd10},
        {OP_IDLE,3'd0, 8'd1,  8'h00, 4'd10},
        {OP_WR,  3'd3, 8'h02, 8'h00, 4'd8},   // R8 trigger without gate
        {OP_RD,  3'd3, 8'h00, 8'h00, 4'd8}    // R8 ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0, ext_trig_in = 1'b0, ext_gate_in = 1'b0;
    logic       tmr_out, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cnt_timer16 i_cnt_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .ext_trig_in(ext_trig_in), .ext_gate_in(ext_gate_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Each operation starts and ends on a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input int req);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(bus_rdata, exp, req, $sformatf("read addr %0d", a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pin(input logic [7:0] exp, input int req);
        #1 check({6'b0, irq, tmr_out}, exp, req, "pins {irq,tmr_out}");
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext(input logic [2:0] v);
        {ext_gate_in, ext_trig_in, ext_clk_in} = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R10 master off, R2 nothing pending, R9 view shows zero
        rd(3'd6, 8'h00, 10);
        rd(3'd3, 8'h00, 2);
        rd(3'd5, 8'h00, 9);
        pin(8'h00, 14);

        // Table walk (R1..R10)
        for (int i = 0; i < NV; i++) begin
            logic [2:0] op; logic [2:0] a; logic [7:0] d; logic [7:0] e; logic [3:0] r;
            {op, a, d, e, r} = VEC[i];
            case (op)
                OP_WR:   wr(a, d);
                OP_RD:   rd(a, e, int'(r));
                OP_PIN:  pin(e, int'(r));
                OP_IDLE: idle(int'(d));
                default: ext(d[2:0]);
            endcase
        end

        // R9 capture freezes the view
        wr(3'd2, 8'h40); wr(3'd0, 8'h20); wr(3'd1, 8'h01);
        wr(3'd3, 8'h03);
        wr(3'd3, 8'h05);
        rd(3'd4, 8'h01, 9);
        rd(3'd5, 8'h20, 9);
        rd(3'd5, 8'h1D, 9);   // R9 released, live count

        // R7 retrigger reloads; without it a trigger is ignored
        wr(3'd2, 8'hC0);
        wr(3'd3, 8'h03);
        rd(3'd5, 8'h20, 7);
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h03);
        rd(3'd5, 8'h1D, 7);
        wr(3'd6, 8'h00); idle(1); wr(3'd6, 8'h01); idle(1);

        // R7 retrigger on the expiring clock; R2 ack on the expiring clock
        wr(3'd2, 8'hC0); wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        wr(3'd3, 8'h03);
        idle(2);
        wr(3'd3, 8'h03);
        rd(3'd3, 8'h21, 7);
        rd(3'd5, 8'h02, 7);
        wr(3'd3, 8'h09);
        rd(3'd3, 8'h41, 2);
        wr(3'd3, 8'h09);

        // R11 external count edges
        wr(3'd2, 8'h48); wr(3'd0, 8'h02);
        wr(3'd3, 8'h03);
        idle(3);
        rd(3'd5, 8'h02, 11);
        ext(3'b001); ext(3'b000);
        rd(3'd5, 8'h01, 11);
        ext(3'b001); ext(3'b000);
        rd(3'd3, 8'h41, 11);
        wr(3'd3, 8'h09);

        // R12 external trigger
        wr(3'd2, 8'h50); idle(1);
        rd(3'd3, 8'h01, 12);
        ext(3'b010);
        rd(3'd3, 8'h21, 12);
        ext(3'b000);
        rd(3'd3, 8'h41, 12);
        wr(3'd3, 8'h09);

        // R13 external gate
        wr(3'd2, 8'h60); wr(3'd0, 8'h03);
        wr(3'd3, 8'h03);
        idle(2);
        rd(3'd5, 8'h03, 13);
        ext(3'b100);
        rd(3'd5, 8'h02, 13);
        ext(3'b000);
        rd(3'd5, 8'h01, 13);
        ext(3'b100); ext(3'b000);
        rd(3'd3, 8'h41, 13);
        wr(3'd3, 8'h09);

        // R14 output enable
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h03);
        pin(8'h00, 14);
        wr(3'd2, 8'h40);
        pin(8'h01, 14);
        pin(8'h02, 14);
        wr(3'd3, 8'h09);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule